// File: doc/BRIEF.md
# Three-Level DMA Address Translation Walker

This block turns a device DMA address into a physical page address. It walks a three-level table kept in system memory. A region table entry points to a segment table. A segment table entry points to a page table. The page table entry holds the page frame.

Each request brings its own context: the DMA address, the function's table origin, an inclusive address window and the function state. The block answers with three things: a page frame address, an address mask, and a permission that is either none or read/write. It reads memory one 64-bit entry at a time through a plain request/response port. Only one walk runs at a time, and a new request is taken only while `req_ready` is high. No translations are cached.

Top module: `xlat_walk_top`

## Requirements
- R1: After reset, `req_ready` is 1 and both `mem_req_valid` and `rsp_valid` are 0.
- R2: A walk is attempted only when `req_xlat_en` is 1 and `req_fn_state` is 2'b10 (enabled) or 2'b11 (blocked). State 2'b00 (standby) and 2'b01 (disabled) give no permission and issue no memory read.
- R3: An address below `req_win_base` or above `req_win_limit` gives no permission and issues no memory read. An address equal to either bound is translated.
- R4: Bit 0 of the table origin is a flag and is cleared before use. The region entry is read from origin + 8 × addr[41:31].
- R5: The region entry's type field is bits [3:2]. A value other than 2'b11 ends the walk with no permission after one read. Otherwise the segment entry is read from (region entry with bits [11:0] cleared) + 8 × addr[30:20].
- R6: The segment entry's type field is bits [3:2]. A value other than 2'b10 ends the walk with no permission after two reads. Otherwise the page entry is read from (segment entry with bits [10:0] cleared) + 8 × addr[19:12].
- R7: A non-zero page entry gives a frame equal to the entry with bits [11:0] cleared, and a mask of 0xFFF. The permission is read/write when bit 10 of the entry is 0, and none when bit 10 is 1.
- R8: A page entry that is all zero gives no permission. The frame is 0 and the mask is all ones.
- R9: Every result that gives no permission for a reason other than R7's invalid bit reports frame 0 and mask all ones. `rsp_valid` is high for exactly one cycle per accepted request.
- R10: `req_ready` stays low from acceptance until the cycle after `rsp_valid`. A memory request that has not been answered is raised for a single cycle only.
- R11: A memory response may arrive in the same cycle as its request or any number of cycles later, and the result is the same.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Translation request strobe |
| req_ready | output | 1 | Walker idle, request accepted when high |
| req_dma_addr | input | 64 | DMA address to translate |
| req_tbl_origin | input | 64 | Region table origin, bit 0 is a flag |
| req_win_base | input | 64 | Lowest allowed DMA address |
| req_win_limit | input | 64 | Highest allowed DMA address (inclusive) |
| req_fn_state | input | 2 | Function state: 00 standby, 01 disabled, 10 enabled, 11 blocked |
| req_xlat_en | input | 1 | Translation switched on for the function |
| mem_req_valid | output | 1 | Memory read request |
| mem_req_addr | output | 64 | Byte address of the 8-byte entry |
| mem_rsp_valid | input | 1 | Memory read data valid |
| mem_rsp_data | input | 64 | Entry read from memory |
| rsp_valid | output | 1 | Result valid for one cycle |
| rsp_frame | output | 64 | Translated page frame address |
| rsp_mask | output | 64 | 0xFFF on a page hit, all ones otherwise |
| rsp_rw | output | 1 | 1 read/write, 0 no permission |

## Verification
The cases that are hardest to reach are walks that stop partway through. In those, the region entry is valid but the segment entry carries the wrong type. A page entry flagged invalid or all zero must also come back with the correct frame and mask. The bench builds a sparse memory image in which tables share a region entry but branch to different segment and page tables. Each failing case then needs only one DMA address. The bench counts memory reads per walk, so a walk that stops too early or too late is seen at the ports. Response latency changes between 0 and 3 cycles from walk to walk, including same-cycle answers.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
   typedef enum logic [2:0] {
      W_IDLE   = 3'd0,
      W_RD_RGN = 3'd1,
      W_RD_SEG = 3'd2,
      W_RD_PG  = 3'd3,
      W_DONE   = 3'd4
   } walk_st_t;

   localparam logic [1:0] FS_ENABLED = 2'b10;
   localparam logic [1:0] FS_BLOCKED = 2'b11;
   localparam logic [1:0] TY_REGION  = 2'b11;
   localparam logic [1:0] TY_SEGMENT = 2'b10;
endpackage

// File: rtl/xlat_gate.sv
module xlat_gate
   import xlat_pkg::*;
#(
   parameter int AW = 64
) (
   input  logic [AW-1:0] dma_addr,
   input  logic [AW-1:0] win_base,
   input  logic [AW-1:0] win_limit,
   input  logic [1:0]    fn_state,
   input  logic          xlat_en,
   output logic          go
);
   logic state_ok;
   logic in_window;

   always_comb begin
      state_ok  = xlat_en && ((fn_state == FS_ENABLED) || (fn_state == FS_BLOCKED));
      in_window = (dma_addr >= win_base) && (dma_addr <= win_limit);
      go        = state_ok && in_window;
   end
endmodule

// File: rtl/xlat_addr.sv
module xlat_addr
   import xlat_pkg::*;
#(
   parameter int AW          = 64,
   parameter int RX_LSB      = 31,
   parameter int RX_W        = 11,
   parameter int SX_LSB      = 20,
   parameter int SX_W        = 11,
   parameter int PX_LSB      = 12,
   parameter int PX_W        = 8,
   parameter int ENTRY_BYTES = 8,
   parameter int ORG_FLAG    = 0
) (
   input  walk_st_t      level,
   input  logic [AW-1:0] dma_addr,
   input  logic [AW-1:0] origin,
   input  logic [AW-1:0] tbl_base,
   output logic [AW-1:0] entry_addr
);
   localparam int ESH = $clog2(ENTRY_BYTES);

   if (RX_LSB + RX_W > AW) begin : g_bad_rx
      $error("region index field exceeds address width");
   end
   if ((PX_LSB + PX_W > SX_LSB) || (SX_LSB + SX_W > RX_LSB)) begin : g_bad_order
      $error("index fields overlap");
   end
   if ((1 << ESH) != ENTRY_BYTES) begin : g_bad_entry
      $error("entry size must be a power of two");
   end

   logic [AW-1:0] org_clean;
   if (ORG_FLAG >= 0) begin : g_flag_mask
      assign org_clean = origin & ~(AW'(1) << ORG_FLAG);
   end else begin : g_no_flag
      assign org_clean = origin;
   end

   logic [AW-1:0] idx;
   logic [AW-1:0] base;

   always_comb begin
      case (level)
         W_RD_RGN: begin
            idx  = AW'(dma_addr[RX_LSB +: RX_W]);
            base = org_clean;
         end
         W_RD_SEG: begin
            idx  = AW'(dma_addr[SX_LSB +: SX_W]);
            base = tbl_base;
         end
         default: begin
            idx  = AW'(dma_addr[PX_LSB +: PX_W]);
            base = tbl_base;
         end
      endcase
      entry_addr = base + (idx << ESH);
   end
endmodule

// File: rtl/xlat_fsm.sv
module xlat_fsm
   import xlat_pkg::*;
#(
   parameter int AW             = 64,
   parameter int TYPE_LSB       = 2,
   parameter int INV_BIT        = 10,
   parameter int STO_LSB        = 12,
   parameter int PTO_LSB        = 11,
   parameter int FRAME_LSB      = 12,
   parameter bit ZERO_PTE_FAULT = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          req_valid,
   input  logic [AW-1:0] req_dma_addr,
   input  logic [AW-1:0] req_tbl_origin,
   input  logic          gate_ok,
   input  logic [AW-1:0] entry_addr,
   output logic          req_ready,
   output walk_st_t      level,
   output logic [AW-1:0] q_addr,
   output logic [AW-1:0] q_origin,
   output logic [AW-1:0] tbl_base,
   output logic          mem_req_valid,
   output logic [AW-1:0] mem_req_addr,
   input  logic          mem_rsp_valid,
   input  logic [AW-1:0] mem_rsp_data,
   output logic          rsp_valid,
   output logic [AW-1:0] rsp_frame,
   output logic [AW-1:0] rsp_mask,
   output logic          rsp_rw
);
   localparam logic [AW-1:0] PG_MASK  = (AW'(1) << FRAME_LSB) - AW'(1);
   localparam logic [AW-1:0] STO_MASK = (AW'(1) << STO_LSB) - AW'(1);
   localparam logic [AW-1:0] PTO_MASK = (AW'(1) << PTO_LSB) - AW'(1);

   walk_st_t st;
   logic     issued;
   logic     pte_void;
   logic [1:0] ent_type;

   if (ZERO_PTE_FAULT) begin : g_zero_fault
      assign pte_void = (mem_rsp_data == '0);
   end else begin : g_zero_pass
      assign pte_void = 1'b0;
   end

   assign ent_type = mem_rsp_data[TYPE_LSB +: 2];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st        <= W_IDLE;
         issued    <= 1'b0;
         q_addr    <= '0;
         q_origin  <= '0;
         tbl_base  <= '0;
         rsp_frame <= '0;
         rsp_mask  <= '0;
         rsp_rw    <= 1'b0;
      end else begin
         case (st)
            W_IDLE: if (req_valid) begin
               q_addr   <= req_dma_addr;
               q_origin <= req_tbl_origin;
               issued   <= 1'b0;
               if (gate_ok) begin
                  st <= W_RD_RGN;
               end else begin
                  rsp_frame <= '0;
                  rsp_mask  <= '1;
                  rsp_rw    <= 1'b0;
                  st        <= W_DONE;
               end
            end
            W_RD_RGN: if (mem_rsp_valid) begin
               issued <= 1'b0;
               if (ent_type == TY_REGION) begin
                  tbl_base <= mem_rsp_data & ~STO_MASK;
                  st       <= W_RD_SEG;
               end else begin
                  rsp_frame <= '0;
                  rsp_mask  <= '1;
                  rsp_rw    <= 1'b0;
                  st        <= W_DONE;
               end
            end else if (!issued) begin
               issued <= 1'b1;
            end
            W_RD_SEG: if (mem_rsp_valid) begin
               issued <= 1'b0;
               if (ent_type == TY_SEGMENT) begin
                  tbl_base <= mem_rsp_data & ~PTO_MASK;
                  st       <= W_RD_PG;
               end else begin
                  rsp_frame <= '0;
                  rsp_mask  <= '1;
                  rsp_rw    <= 1'b0;
                  st        <= W_DONE;
               end
            end else if (!issued) begin
               issued <= 1'b1;
            end
            W_RD_PG: if (mem_rsp_valid) begin
               issued <= 1'b0;
               st     <= W_DONE;
               if (pte_void) begin
                  rsp_frame <= '0;
                  rsp_mask  <= '1;
                  rsp_rw    <= 1'b0;
               end else begin
                  rsp_frame <= mem_rsp_data & ~PG_MASK;
                  rsp_mask  <= PG_MASK;
                  rsp_rw    <= !mem_rsp_data[INV_BIT];
               end
            end else if (!issued) begin
               issued <= 1'b1;
            end
            default: st <= W_IDLE;
         endcase
      end
   end

   assign level         = st;
   assign req_ready     = (st == W_IDLE);
   assign mem_req_valid = ((st == W_RD_RGN) || (st == W_RD_SEG) || (st == W_RD_PG)) && !issued;
   assign mem_req_addr  = entry_addr;
   assign rsp_valid     = (st == W_DONE);

   // R10: an idle walker never reads memory
   a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> !mem_req_valid);
   // R10: an unanswered read request is a single-cycle pulse
   a_r10_req_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_valid && !mem_rsp_valid) |=> !mem_req_valid);
   // R9: one result cycle, then ready again
   a_r9_single_rsp: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> (!rsp_valid && req_ready));
   // R2/R3: a rejected request answers next cycle with no permission
   a_r3_reject_fast: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready && !gate_ok) |=> (rsp_valid && !rsp_rw && (rsp_mask == '1)));
   // R7: a granted permission always carries the page mask
   a_r7_page_mask: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_rw) |-> (rsp_mask == PG_MASK));
endmodule

// File: rtl/xlat_walk_top.sv
module xlat_walk_top
   import xlat_pkg::*;
#(
   parameter int AW             = 64,
   parameter int RX_LSB         = 31,
   parameter int RX_W           = 11,
   parameter int SX_LSB         = 20,
   parameter int SX_W           = 11,
   parameter int PX_LSB         = 12,
   parameter int PX_W           = 8,
   parameter int ENTRY_BYTES    = 8,
   parameter int ORG_FLAG       = 0,
   parameter int TYPE_LSB       = 2,
   parameter int INV_BIT        = 10,
   parameter int STO_LSB        = 12,
   parameter int PTO_LSB        = 11,
   parameter bit ZERO_PTE_FAULT = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          req_valid,
   output logic          req_ready,
   input  logic [AW-1:0] req_dma_addr,
   input  logic [AW-1:0] req_tbl_origin,
   input  logic [AW-1:0] req_win_base,
   input  logic [AW-1:0] req_win_limit,
   input  logic [1:0]    req_fn_state,
   input  logic          req_xlat_en,
   output logic          mem_req_valid,
   output logic [AW-1:0] mem_req_addr,
   input  logic          mem_rsp_valid,
   input  logic [AW-1:0] mem_rsp_data,
   output logic          rsp_valid,
   output logic [AW-1:0] rsp_frame,
   output logic [AW-1:0] rsp_mask,
   output logic          rsp_rw
);
   logic          gate_ok;
   walk_st_t      level;
   logic [AW-1:0] q_addr;
   logic [AW-1:0] q_origin;
   logic [AW-1:0] tbl_base;
   logic [AW-1:0] entry_addr;

   xlat_gate #(.AW(AW)) u_gate (
      .dma_addr  (req_dma_addr),
      .win_base  (req_win_base),
      .win_limit (req_win_limit),
      .fn_state  (req_fn_state),
      .xlat_en   (req_xlat_en),
      .go        (gate_ok)
   );

   xlat_addr #(
      .AW(AW), .RX_LSB(RX_LSB), .RX_W(RX_W), .SX_LSB(SX_LSB), .SX_W(SX_W),
      .PX_LSB(PX_LSB), .PX_W(PX_W), .ENTRY_BYTES(ENTRY_BYTES), .ORG_FLAG(ORG_FLAG)
   ) u_addr (
      .level      (level),
      .dma_addr   (q_addr),
      .origin     (q_origin),
      .tbl_base   (tbl_base),
      .entry_addr (entry_addr)
   );

   xlat_fsm #(
      .AW(AW), .TYPE_LSB(TYPE_LSB), .INV_BIT(INV_BIT), .STO_LSB(STO_LSB),
      .PTO_LSB(PTO_LSB), .FRAME_LSB(PX_LSB), .ZERO_PTE_FAULT(ZERO_PTE_FAULT)
   ) u_fsm (
      .clk            (clk),
      .rst_n          (rst_n),
      .req_valid      (req_valid),
      .req_dma_addr   (req_dma_addr),
      .req_tbl_origin (req_tbl_origin),
      .gate_ok        (gate_ok),
      .entry_addr     (entry_addr),
      .req_ready      (req_ready),
      .level          (level),
      .q_addr         (q_addr),
      .q_origin       (q_origin),
      .tbl_base       (tbl_base),
      .mem_req_valid  (mem_req_valid),
      .mem_req_addr   (mem_req_addr),
      .mem_rsp_valid  (mem_rsp_valid),
      .mem_rsp_data   (mem_rsp_data),
      .rsp_valid      (rsp_valid),
      .rsp_frame      (rsp_frame),
      .rsp_mask       (rsp_mask),
      .rsp_rw         (rsp_rw)
   );
endmodule

// File: tb/xlat_walk_top_test.sv
`timescale 1ns/1ps
module xlat_walk_top_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [63:0] req_dma_addr = '0;
   logic [63:0] req_tbl_origin = '0;
   logic [63:0] req_win_base = '0;
   logic [63:0] req_win_limit = '0;
   logic [1:0]  req_fn_state = 2'b00;
   logic        req_xlat_en = 1'b0;
   logic        mem_req_valid;
   logic [63:0] mem_req_addr;
   logic        mem_rsp_valid = 1'b0;
   logic [63:0] mem_rsp_data = '0;
   logic        rsp_valid;
   logic [63:0] rsp_frame;
   logic [63:0] rsp_mask;
   logic        rsp_rw;

   always #2 clk = ~clk;

   xlat_walk_top uut (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready),
      .req_dma_addr(req_dma_addr), .req_tbl_origin(req_tbl_origin),
      .req_win_base(req_win_base), .req_win_limit(req_win_limit),
      .req_fn_state(req_fn_state), .req_xlat_en(req_xlat_en),
      .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
      .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
      .rsp_valid(rsp_valid), .rsp_frame(rsp_frame),
      .rsp_mask(rsp_mask), .rsp_rw(rsp_rw)
   );

   int checks = 0;
   int errors = 0;
   int rd_cnt = 0;
   int lat = 0;
   bit finished = 1'b0;

   logic [63:0] mem [logic [63:0]];

   typedef struct {
      logic [63:0] frame;
      logic [63:0] mask;
      logic        rw;
      int          reads;
      int          start;
      string       tag;
   } exp_t;
   exp_t sb_q[$];

   task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [63:0] rd(input logic [63:0] a);
      if (mem.exists(a)) return mem[a];
      return 64'h0;
   endfunction

   function automatic logic [63:0] mk(input int rx, input int sx, input int px, input int off);
      return (64'(rx) << 31) | (64'(sx) << 20) | (64'(px) << 12) | 64'(off);
   endfunction

   // Reference walk built from the requirements
   function automatic exp_t model(input logic [63:0] a, input logic [63:0] org,
                                  input logic [63:0] lo, input logic [63:0] hi,
                                  input logic [1:0] fs, input logic en);
      exp_t e;
      logic [63:0] ent;
      e.frame = '0; e.mask = '1; e.rw = 1'b0; e.reads = 0; e.start = 0; e.tag = "";
      if (!(en && (fs == 2'b10 || fs == 2'b11))) return e;
      if (a < lo || a > hi) return e;
      ent = rd((org & ~64'h1) + 64'(a[41:31]) * 8);
      e.reads = 1;
      if (ent[3:2] != 2'b11) return e;
      ent = rd((ent & ~64'hFFF) + 64'(a[30:20]) * 8);
      e.reads = 2;
      if (ent[3:2] != 2'b10) return e;
      ent = rd((ent & ~64'h7FF) + 64'(a[19:12]) * 8);
      e.reads = 3;
      if (ent == 64'h0) return e;
      e.frame = ent & ~64'hFFF;
      e.mask  = 64'hFFF;
      e.rw    = !ent[10];
      return e;
   endfunction

   task automatic go(input logic [63:0] a, input logic [63:0] org,
                     input logic [63:0] lo, input logic [63:0] hi,
                     input logic [1:0] fs, input logic en, input string tag);
      exp_t e;
      e = model(a, org, lo, hi, fs, en);
      e.tag = tag;
      @(negedge clk);
      while (!req_ready) @(negedge clk);
      req_dma_addr = a; req_tbl_origin = org; req_win_base = lo;
      req_win_limit = hi; req_fn_state = fs; req_xlat_en = en;
      req_valid = 1'b1;
      e.start = rd_cnt;
      sb_q.push_back(e);
      @(posedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      chk(req_ready == 1'b0, {"R10 busy after accept ", tag}, 64'(req_ready), 64'h0);
      while (!req_ready) @(negedge clk);
      lat = (lat + 1) % 4;
   endtask

   // Memory responder (R11: variable latency, including zero)
   initial begin
      logic [63:0] a;
      forever begin
         @(negedge clk);
         mem_rsp_valid = 1'b0;
         if (mem_req_valid) begin
            rd_cnt++;
            a = mem_req_addr;
            repeat (lat) @(negedge clk);
            mem_rsp_data  = rd(a);
            mem_rsp_valid = 1'b1;
         end
      end
   end

   // Scoreboard monitor
   initial begin
      exp_t e;
      forever begin
         @(negedge clk);
         if (rsp_valid) begin
            if (sb_q.size() == 0) begin
               chk(1'b0, "R9 unexpected result", 64'h1, 64'h0);
            end else begin
               e = sb_q.pop_front();
               chk(rsp_frame == e.frame, {e.tag, " frame"}, rsp_frame, e.frame);
               chk(rsp_mask == e.mask, {e.tag, " mask"}, rsp_mask, e.mask);
               chk(rsp_rw == e.rw, {e.tag, " perm"}, 64'(rsp_rw), 64'(e.rw));
               chk((rd_cnt - e.start) == e.reads, {e.tag, " reads"},
                   64'(rd_cnt - e.start), 64'(e.reads));
            end
         end
      end
   end

   // Watchdog
   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         errors++;
         $display("FAIL watchdog expired actual=%h expected=%h", 64'h0, 64'h1);
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   localparam logic [63:0] ORG   = 64'h0000_0000_0010_0000;
   localparam logic [63:0] STO_A = 64'h0000_0000_0020_0000;
   localparam logic [63:0] PTO_A = 64'h0000_0000_0030_0800;
   localparam logic [63:0] STO_B = 64'h0000_0000_0040_0000;
   localparam logic [63:0] PTO_B = 64'h0000_0000_0050_0000;
   localparam logic [63:0] PTO_C = 64'h0000_0000_0030_1000;
   localparam logic [63:0] ALL   = 64'hFFFF_FFFF_FFFF_FFFF;

   initial begin
      logic [63:0] a;
      // Table image
      mem[ORG + 3*8]        = STO_A | 64'hC;
      mem[STO_A + 5*8]      = PTO_A | 64'h8;
      mem[PTO_A + 7*8]      = 64'h0000_00AB_CDEF_5000;
      mem[ORG + 64'h7FF*8]  = STO_B | 64'hC;
      mem[STO_B + 64'h7FF*8]= PTO_B | 64'hB;
      mem[PTO_B + 64'hFF*8] = 64'h0000_0012_3456_70F0;
      mem[STO_A + 6*8]      = PTO_C | 64'h8;
      mem[PTO_C + 1*8]      = 64'h0000_0000_9876_5400;
      mem[ORG + 9*8]        = 64'h0000_0000_0060_0008;
      mem[STO_A + 7*8]      = 64'h0000_0000_0070_000C;

      repeat (3) @(posedge clk);
      @(negedge clk);
      chk(req_ready == 1'b1, "R1 ready", 64'(req_ready), 64'h1);
      chk(mem_req_valid == 1'b0, "R1 mem idle", 64'(mem_req_valid), 64'h0);
      chk(rsp_valid == 1'b0, "R1 no result", 64'(rsp_valid), 64'h0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(req_ready == 1'b1, "R1 ready after release", 64'(req_ready), 64'h1);

      a = mk(3, 5, 7, 'h123);
      go(a, ORG, 0, ALL, 2'b10, 1'b1, "R4 R5 R6 R7 full walk enabled");
      go(a, ORG, 0, ALL, 2'b11, 1'b1, "R2 blocked state walks");
      go(a, ORG, 0, ALL, 2'b01, 1'b1, "R2 disabled rejected");
      go(a, ORG, 0, ALL, 2'b00, 1'b1, "R2 standby rejected");
      go(a, ORG, 0, ALL, 2'b10, 1'b0, "R2 translation off");
      go(a, ORG | 64'h1, 0, ALL, 2'b10, 1'b1, "R4 origin flag ignored");
      go(a, ORG, a + 1, ALL, 2'b10, 1'b1, "R3 below base");
      go(a, ORG, 0, a - 1, 2'b10, 1'b1, "R3 above limit");
      go(a, ORG, a, a, 2'b10, 1'b1, "R3 equal to both bounds");
      go(mk('h7FF, 'h7FF, 'hFF, 'hFFF), ORG, 0, ALL, 2'b11, 1'b1, "R6 max indices low bits masked");
      go(mk(3, 6, 1, 0), ORG, 0, ALL, 2'b10, 1'b1, "R7 invalid page entry");
      go(mk(3, 6, 2, 0), ORG, 0, ALL, 2'b10, 1'b1, "R8 zero page entry");
      go(mk(9, 0, 0, 0), ORG, 0, ALL, 2'b10, 1'b1, "R5 region type mismatch");
      go(mk(20, 1, 1, 0), ORG, 0, ALL, 2'b10, 1'b1, "R5 empty region entry");
      go(mk(3, 7, 0, 0), ORG, 0, ALL, 2'b10, 1'b1, "R6 segment type mismatch");
      for (int i = 0; i < 4; i++) begin
         lat = i;
         go(a, ORG, 0, ALL, 2'b10, 1'b1, "R11 latency sweep");
      end
      repeat (3) @(negedge clk);
      chk(sb_q.size() == 0, "R9 all results seen", 64'(sb_q.size()), 64'h0);
      finished = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule